// File: doc/BRIEF.md
# Oversubscribed Warp Issue Scheduler

This block chooses, on every clock, one warp to issue from a pool of up to 64 warps resident on a single compute unit. The pool is much larger than the number of warps that can execute at the same time. A warp can be chosen only if it is resident, is not held at a barrier, and is not waiting on a long-latency operation. Because every warp's execution state is held in hardware, the scheduler can name a different warp on each consecutive cycle at no cost. Warps that are waiting are skipped, so a slow warp never holds back a ready one.

Stalls arrive on a single set port. A timed stall carries a latency and expires by itself; this covers pipelined arithmetic and branch resolution. A memory stall lasts until a completion event names the same warp. A separate mask holds warps at a barrier. The block makes its decision from the inputs and stall state of the current cycle and registers it. The chosen warp, a valid flag, and a lane mask covering all threads of the warp appear on the next cycle. Instruction fetch, decode and execution are handled elsewhere.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, issue_vld is 0 and issue_lanes is all zeros. The first search after reset starts at warp 0.
- R2: A warp is issued only if, in the deciding cycle, its warp_valid bit was 1, its bar_mask bit was 0, it had no stall pending, and it was not the target of stall_set in that same cycle.
- R3: Round-robin priority: the search for the next warp begins at the index one above the last issued warp and wraps from NUM_WARPS-1 to 0.
- R4: If no warp is eligible in a cycle, issue_vld is 0 on the next cycle.
- R5: Whenever at least one warp is eligible, issue_vld is 1 on the next cycle. Switching warps inserts no idle cycle, so with all warps eligible the ids issued on successive cycles are consecutive.
- R6: A stall_set with stall_set_mem=0 and latency N makes the warp ineligible for exactly N+1 decisions, starting with the decision in the set cycle. Other warps are unaffected.
- R7: A stall_set with stall_set_mem=1 makes the warp ineligible until a done event (done_vld=1 with done_id equal to the warp). The warp can be chosen from the decision in the cycle after that event.
- R8: A done event for a warp with no memory stall has no effect. If a set and a done event name the same warp in the same cycle, the set wins.
- R9: A warp whose bar_mask bit is 1 is never issued. It becomes eligible in the decision of the first cycle in which that bit is 0.
- R10: issue_lanes is all ones (LANES bits) whenever issue_vld is 1, and all zeros otherwise.
- R11: A stall_set on a warp that is already stalled replaces that warp's stall kind and latency.
- R12: The round-robin pointer holds its value through cycles with no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| warp_valid | input | NUM_WARPS | Resident-warp mask |
| bar_mask | input | NUM_WARPS | Warps held at a barrier |
| stall_set_vld | input | 1 | Stall set strobe |
| stall_set_id | input | $clog2(NUM_WARPS) | Warp to stall |
| stall_set_mem | input | 1 | 1: memory stall released by a done event; 0: timed stall |
| stall_set_lat | input | LAT_W | Latency in cycles for a timed stall |
| done_vld | input | 1 | Completion event strobe |
| done_id | input | $clog2(NUM_WARPS) | Warp whose memory operation completed |
| issue_vld | output | 1 | A warp is issued this cycle |
| issue_id | output | $clog2(NUM_WARPS) | Issued warp |
| issue_lanes | output | LANES | Thread mask of the issued warp |

## Verification
The bench checks the exact length of a timed stall. A counter that is off by one would release the warp one decision early or one decision late, and the bench counts the idle cycles in between. It holds a memory stall for many cycles and then delivers a set and a completion event for the same warp in the same cycle. A design that gives the completion event priority, or that lets a stray completion release a warp, would issue that warp when it should stay idle. It checks where the round-robin search resumes after idle cycles and after a barrier clears. A design that resets its pointer, or that searches from the last issued warp itself rather than the one above it, would issue a different warp than expected.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
    parameter int unsigned DEF_WARPS = 64;
    parameter int unsigned DEF_LAT_W = 8;
    parameter int unsigned DEF_LANES = 32;

    typedef enum logic {
        STALL_TIMED = 1'b0,
        STALL_MEM   = 1'b1
    } stall_kind_e;
endpackage

// File: rtl/warp_stall_slot.sv
module warp_stall_slot
    import warp_sched_pkg::*;
#(
    parameter int unsigned LAT_W = DEF_LAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_hit,
    input  logic             set_mem,
    input  logic [LAT_W-1:0] set_lat,
    input  logic             done_hit,
    output logic             stalled
);
    typedef struct packed {
        logic             mem;
        logic [LAT_W-1:0] cnt;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (set_hit) begin
            if (stall_kind_e'(set_mem) == STALL_MEM) begin
                slot_d.mem = 1'b1;
                slot_d.cnt = '0;
            end else begin
                slot_d.mem = 1'b0;
                slot_d.cnt = set_lat;
            end
        end else begin
            if (done_hit) begin
                slot_d.mem = 1'b0;
            end
            if (slot_q.cnt != '0) begin
                slot_d.cnt = slot_q.cnt - LAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign stalled = slot_q.mem || (slot_q.cnt != '0);
endmodule

// File: rtl/warp_rr_picker.sv
module warp_rr_picker
    import warp_sched_pkg::*;
#(
    parameter int unsigned NUM_WARPS = DEF_WARPS,
    localparam int unsigned IDW = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] elig,
    input  logic [IDW-1:0]       last,
    output logic                 found,
    output logic [IDW-1:0]       pick
);
    localparam logic [IDW:0] NW_X = (IDW+1)'(NUM_WARPS);

    logic [IDW-1:0]          start;
    logic [2*NUM_WARPS-1:0]  dbl;
    logic [NUM_WARPS-1:0]    rot;
    logic [IDW-1:0]          off;
    logic [IDW:0]            sum;
    logic [IDW:0]            sum_w;

    always_comb begin
        start = (last == IDW'(NUM_WARPS - 1)) ? '0 : last + IDW'(1);
        dbl   = {elig, elig} >> start;
        rot   = dbl[NUM_WARPS-1:0];
        found = 1'b0;
        off   = '0;
        for (int i = NUM_WARPS - 1; i >= 0; i--) begin
            if (rot[i]) begin
                found = 1'b1;
                off   = IDW'(i);
            end
        end
        sum   = {1'b0, start} + {1'b0, off};
        sum_w = (sum >= NW_X) ? (sum - NW_X) : sum;
        pick  = sum_w[IDW-1:0];
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int unsigned NUM_WARPS = DEF_WARPS,
    parameter int unsigned LAT_W     = DEF_LAT_W,
    parameter int unsigned LANES     = DEF_LANES,
    localparam int unsigned IDW      = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] warp_valid,
    input  logic [NUM_WARPS-1:0] bar_mask,
    input  logic                 stall_set_vld,
    input  logic [IDW-1:0]       stall_set_id,
    input  logic                 stall_set_mem,
    input  logic [LAT_W-1:0]     stall_set_lat,
    input  logic                 done_vld,
    input  logic [IDW-1:0]       done_id,
    output logic                 issue_vld,
    output logic [IDW-1:0]       issue_id,
    output logic [LANES-1:0]     issue_lanes
);
    typedef struct packed {
        logic             vld;
        logic [IDW-1:0]   id;
        logic [IDW-1:0]   last;
        logic [LANES-1:0] lanes;
    } issue_t;

    logic [NUM_WARPS-1:0] set_hit;
    logic [NUM_WARPS-1:0] done_hit;
    logic [NUM_WARPS-1:0] stalled;
    logic [NUM_WARPS-1:0] elig;
    logic                 found;
    logic [IDW-1:0]       pick;
    issue_t               st_d, st_q;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        assign set_hit[w]  = stall_set_vld && (stall_set_id == IDW'(w));
        assign done_hit[w] = done_vld && (done_id == IDW'(w));

        warp_stall_slot #(.LAT_W(LAT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_hit  (set_hit[w]),
            .set_mem  (stall_set_mem),
            .set_lat  (stall_set_lat),
            .done_hit (done_hit[w]),
            .stalled  (stalled[w])
        );

        assign elig[w] = warp_valid[w] && !bar_mask[w] && !stalled[w] && !set_hit[w];
    end

    warp_rr_picker #(.NUM_WARPS(NUM_WARPS)) u_pick (
        .elig  (elig),
        .last  (st_q.last),
        .found (found),
        .pick  (pick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = found;
        st_d.lanes = found ? '1 : '0;
        if (found) begin
            st_d.id   = pick;
            st_d.last = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld   <= 1'b0;
            st_q.id    <= '0;
            st_q.last  <= IDW'(NUM_WARPS - 1);
            st_q.lanes <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_vld   = st_q.vld;
    assign issue_id    = st_q.id;
    assign issue_lanes = st_q.lanes;
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
    parameter int unsigned NUM_WARPS = 64,
    parameter int unsigned LANES     = 32,
    localparam int unsigned IDW      = $clog2(NUM_WARPS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WARPS-1:0] warp_valid,
    input logic [NUM_WARPS-1:0] bar_mask,
    input logic                 stall_set_vld,
    input logic [IDW-1:0]       stall_set_id,
    input logic                 issue_vld,
    input logic [IDW-1:0]       issue_id,
    input logic [LANES-1:0]     issue_lanes
);
    logic [NUM_WARPS-1:0] prev_valid_q;
    logic [NUM_WARPS-1:0] prev_bar_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid_q <= '0;
            prev_bar_q   <= '0;
        end else begin
            prev_valid_q <= warp_valid;
            prev_bar_q   <= bar_mask;
        end
    end

    AST_ISSUED_WAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> (prev_valid_q[issue_id] && !prev_bar_q[issue_id])); // R2
    AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((prev_valid_q & ~prev_bar_q) == '0) |-> !issue_vld); // R4
    AST_LANES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> (&issue_lanes)); // R10
    AST_LANES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |-> (issue_lanes == '0)); // R10
    AST_SET_SKIPS_WARP: assert property (@(posedge clk) disable iff (!rst_n)
        stall_set_vld |=> !(issue_vld && (issue_id == $past(stall_set_id)))); // R6
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
    .NUM_WARPS (NUM_WARPS),
    .LANES     (LANES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .warp_valid    (warp_valid),
    .bar_mask      (bar_mask),
    .stall_set_vld (stall_set_vld),
    .stall_set_id  (stall_set_id),
    .issue_vld     (issue_vld),
    .issue_id      (issue_id),
    .issue_lanes   (issue_lanes)
);

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;
    localparam int NW    = 64;
    localparam int LAT_W = 8;
    localparam int LANES = 32;
    localparam int IDW   = $clog2(NW);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NW-1:0]    warp_valid = '0;
    logic [NW-1:0]    bar_mask = '0;
    logic             stall_set_vld = 1'b0;
    logic [IDW-1:0]   stall_set_id = '0;
    logic             stall_set_mem = 1'b0;
    logic [LAT_W-1:0] stall_set_lat = '0;
    logic             done_vld = 1'b0;
    logic [IDW-1:0]   done_id = '0;
    logic             issue_vld;
    logic [IDW-1:0]   issue_id;
    logic [LANES-1:0] issue_lanes;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .LAT_W(LAT_W), .LANES(LANES)) u_warp_issue_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .warp_valid    (warp_valid),
        .bar_mask      (bar_mask),
        .stall_set_vld (stall_set_vld),
        .stall_set_id  (stall_set_id),
        .stall_set_mem (stall_set_mem),
        .stall_set_lat (stall_set_lat),
        .done_vld      (done_vld),
        .done_id       (done_id),
        .issue_vld     (issue_vld),
        .issue_id      (issue_id),
        .issue_lanes   (issue_lanes)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_issue(string req, bit exp_vld, int exp_id);
        logic [LANES-1:0] exp_lanes;
        exp_lanes = exp_vld ? '1 : '0;
        checks++;
        if (issue_vld !== exp_vld || issue_lanes !== exp_lanes ||
            (exp_vld && issue_id !== IDW'(exp_id))) begin
            errors++;
            $display("FAIL %s: vld=%0b id=%0d lanes=%h expected vld=%0b id=%0d lanes=%h",
                     req, issue_vld, issue_id, issue_lanes, exp_vld, exp_id, exp_lanes);
        end
    endtask

    task automatic set_stall(int id, bit mem, int lat);
        stall_set_vld = 1'b1;
        stall_set_id  = IDW'(id);
        stall_set_mem = mem;
        stall_set_lat = LAT_W'(lat);
    endtask

    task automatic clear_strobes();
        stall_set_vld = 1'b0;
        done_vld      = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        warp_valid = '0;
        bar_mask = '0;
        clear_strobes();
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // R1: outputs quiet in reset even with warps ready
    task automatic t_reset();
        rst_n = 1'b0;
        warp_valid = '1;
        tick();
        expect_issue("R1", 1'b0, 0);
        tick();
        expect_issue("R1", 1'b0, 0);
        do_reset();
    endtask

    // R3 R5 R10: all ready gives consecutive ids, starting at 0 after reset
    task automatic t_all_ready();
        do_reset();
        warp_valid = '1;
        for (int k = 0; k < 5; k++) begin
            tick();
            expect_issue("R5", 1'b1, k);
        end
    endtask

    // R3: sparse pool alternates
    task automatic t_sparse();
        do_reset();
        warp_valid = '0;
        warp_valid[5] = 1'b1;
        warp_valid[9] = 1'b1;
        tick(); expect_issue("R3", 1'b1, 5);
        tick(); expect_issue("R3", 1'b1, 9);
        tick(); expect_issue("R3", 1'b1, 5);
    endtask

    // R4 R12: idle keeps the pointer
    task automatic t_idle_pointer();
        do_reset();
        warp_valid = '0;
        warp_valid[3] = 1'b1;
        tick(); expect_issue("R12", 1'b1, 3);
        warp_valid = '0;
        tick(); expect_issue("R4", 1'b0, 0);
        tick(); expect_issue("R4", 1'b0, 0);
        warp_valid[2] = 1'b1;
        warp_valid[7] = 1'b1;
        tick(); expect_issue("R12", 1'b1, 7);
        tick(); expect_issue("R12", 1'b1, 2);
    endtask

    // R9: barrier hold and release
    task automatic t_barrier();
        do_reset();
        warp_valid = '0;
        warp_valid[1] = 1'b1;
        warp_valid[2] = 1'b1;
        bar_mask[1] = 1'b1;
        tick(); expect_issue("R9", 1'b1, 2);
        tick(); expect_issue("R9", 1'b1, 2);
        bar_mask = '0;
        tick(); expect_issue("R9", 1'b1, 1);
        tick(); expect_issue("R9", 1'b1, 2);
    endtask

    // R6: timed stall of latency 3 blocks 4 decisions
    task automatic t_timed_stall();
        do_reset();
        warp_valid = '0;
        warp_valid[4] = 1'b1;
        tick(); expect_issue("R6", 1'b1, 4);
        set_stall(4, 1'b0, 3);
        tick(); expect_issue("R6", 1'b0, 0);
        clear_strobes();
        for (int k = 0; k < 3; k++) begin
            tick(); expect_issue("R6", 1'b0, 0);
        end
        tick(); expect_issue("R6", 1'b1, 4);
    endtask

    // R6 R2: stalled warp does not block others
    task automatic t_stall_others();
        do_reset();
        warp_valid = '0;
        warp_valid[0] = 1'b1;
        warp_valid[1] = 1'b1;
        set_stall(0, 1'b1, 0);
        tick(); expect_issue("R2", 1'b1, 1);
        clear_strobes();
        tick(); expect_issue("R6", 1'b1, 1);
        tick(); expect_issue("R6", 1'b1, 1);
    endtask

    // R7: memory stall waits for the done event
    task automatic t_mem_stall();
        do_reset();
        warp_valid = '0;
        warp_valid[6] = 1'b1;
        set_stall(6, 1'b1, 2);
        tick(); expect_issue("R7", 1'b0, 0);
        clear_strobes();
        for (int k = 0; k < 8; k++) begin
            tick(); expect_issue("R7", 1'b0, 0);
        end
        done_vld = 1'b1;
        done_id  = IDW'(6);
        tick(); expect_issue("R7", 1'b0, 0);
        clear_strobes();
        tick(); expect_issue("R7", 1'b1, 6);
    endtask

    // R8: stray done ignored; set beats done in the same cycle
    task automatic t_done_rules();
        do_reset();
        warp_valid = '0;
        warp_valid[0] = 1'b1;
        warp_valid[1] = 1'b1;
        done_vld = 1'b1;
        done_id  = IDW'(1);
        tick(); expect_issue("R8", 1'b1, 0);
        tick(); expect_issue("R8", 1'b1, 1);
        tick(); expect_issue("R8", 1'b1, 0);
        clear_strobes();
        do_reset();
        warp_valid = '0;
        warp_valid[1] = 1'b1;
        set_stall(1, 1'b1, 0);
        done_vld = 1'b1;
        done_id  = IDW'(1);
        tick(); expect_issue("R8", 1'b0, 0);
        clear_strobes();
        tick(); expect_issue("R8", 1'b0, 0);
        tick(); expect_issue("R8", 1'b0, 0);
        done_vld = 1'b1;
        tick(); expect_issue("R8", 1'b0, 0);
        clear_strobes();
        tick(); expect_issue("R8", 1'b1, 1);
    endtask

    // R11: a timed set replaces a memory stall
    task automatic t_reset_stall();
        do_reset();
        warp_valid = '0;
        warp_valid[2] = 1'b1;
        set_stall(2, 1'b1, 0);
        tick(); expect_issue("R11", 1'b0, 0);
        clear_strobes();
        tick(); expect_issue("R11", 1'b0, 0);
        set_stall(2, 1'b0, 1);
        tick(); expect_issue("R11", 1'b0, 0);
        clear_strobes();
        tick(); expect_issue("R11", 1'b0, 0);
        tick(); expect_issue("R11", 1'b1, 2);
    endtask

    initial begin
        tick();
        t_reset();
        t_all_ready();
        t_sparse();
        t_idle_pointer();
        t_barrier();
        t_timed_stall();
        t_stall_others();
        t_mem_stall();
        t_done_rules();
        t_reset_stall();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: vld=%0b id=%0d expected run to complete", issue_vld, issue_id);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule